// File: doc/BRIEF.md
# FIFO-Replaced Branch Target Buffer

This block is a small, fully associative branch target buffer for an instruction fetch unit. Each of its entries remembers where a branch sits (a virtual address tag plus the instruction-space bit that was current when the branch was seen), where it went, and a 2-bit history counter. The fetch stage presents its fetch address and current instruction-space bit every cycle. It gets back, in the same cycle, whether the buffer knows the branch, whether it predicts the branch taken, and the stored target.

The branch-resolution stage reports every resolved branch on the update port. A branch that already has an entry trains that entry's counter. A taken branch without an entry gets a new entry if the allocation filter accepts its direction. Victims are replaced strictly in arrival order. An explicit flush input and a pulse marking a write of the process-ID register both wipe the buffer. Clearing the enable turns off dynamic prediction entirely.

Top module: `brtgt_buf`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports hit=0 and taken=0.
- R2: With the buffer enabled, a taken branch that misses and passes the allocation filter gets an entry. From the next cycle, a lookup of that address with the same instruction-space bit reports hit=1, taken=1 and the stored target. The new counter holds 2'b10 (weakly taken).
- R3: A resolved not-taken branch that has no entry allocates nothing.
- R4: The counter encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken, 11 strongly taken. A hit branch increments the counter when it resolves taken and decrements it when it resolves not-taken. The counter saturates at 11 and at 00. A hit predicts taken exactly when counter bit 1 is set.
- R5: Bit 0 of alloc_mode_i permits forward branches (upd_backward_i=0) to allocate, and bit 1 permits backward branches. The filter does not affect counter updates to entries that already exist.
- R6: A lookup hits only when both the 31-bit address and the instruction-space bit match a valid entry.
- R7: New entries go into slots in FIFO order. With all slots full, the next allocation replaces the oldest entry and leaves the rest intact.
- R8: A taken branch that already has an entry is not allocated again, and the FIFO pointer does not advance.
- R9: A cycle with flush_i or pid_wr_i high invalidates every entry and returns the FIFO pointer to slot 0.
- R10: While en_i is low, every lookup misses and updates neither allocate nor change counters. Entries are kept and reappear when en_i is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Dynamic prediction enable |
| alloc_mode_i | input | 2 | Allocation filter: bit 0 forward, bit 1 backward |
| flush_i | input | 1 | Explicit flush of all entries |
| pid_wr_i | input | 1 | Process-ID register written; flushes all entries |
| lk_addr_i | input | 31 | Fetch lookup address |
| lk_is_i | input | 1 | Current instruction-space bit for lookup |
| lk_hit_o | output | 1 | Lookup matched a valid entry |
| lk_taken_o | output | 1 | Lookup predicts taken |
| lk_target_o | output | 31 | Stored target on hit, zero on miss |
| upd_valid_i | input | 1 | Resolved branch present on update port |
| upd_addr_i | input | 31 | Resolved branch address |
| upd_is_i | input | 1 | Instruction-space bit of resolved branch |
| upd_taken_i | input | 1 | Resolved direction |
| upd_target_i | input | 31 | Resolved target address |
| upd_backward_i | input | 1 | Branch is backward (1) or forward (0) |

## Verification
A corrupted counter appears at the lookup port in the very next cycle, as a flipped taken bit on a hit. This is why the counter walks are probed after every single update, at both saturation points. A wrong FIFO pointer stays hidden until the buffer fills, and then shows as the wrong address missing on the ninth allocation. The replacement tests therefore fill every slot and check each survivor. A stale valid bit after a flush, or an entry allocated while the block is disabled, shows as a lookup hit one cycle after the event.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;
endpackage

// File: rtl/brtgt_entry.sv
module brtgt_entry
  import brtgt_pkg::*;
#(
  parameter int AW = 31
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          alloc_i,
  input  logic          train_i,
  input  logic          taken_i,
  input  logic [AW-1:0] addr_i,
  input  logic          is_i,
  input  logic [AW-1:0] tgt_i,
  output logic          valid_o,
  output logic [AW-1:0] tag_o,
  output logic          is_o,
  output logic [AW-1:0] tgt_o,
  output logic [1:0]    cnt_o
);
  logic          valid_q;
  logic [AW-1:0] tag_q, tgt_q;
  logic          is_q;
  ctr_e          cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      is_q    <= 1'b0;
      tgt_q   <= '0;
      cnt_q   <= CTR_SNT;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      tag_q   <= addr_i;
      is_q    <= is_i;
      tgt_q   <= tgt_i;
      cnt_q   <= CTR_WT;
    end else if (train_i) begin
      if (taken_i && cnt_q != CTR_ST)       cnt_q <= ctr_e'(cnt_q + 2'd1);
      else if (!taken_i && cnt_q != CTR_SNT) cnt_q <= ctr_e'(cnt_q - 2'd1);
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign is_o    = is_q;
  assign tgt_o   = tgt_q;
  assign cnt_o   = cnt_q;

  AST_ALLOC_WT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i && !clr_i |=> valid_q && cnt_q == CTR_WT); // R2
  AST_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_i && taken_i && !alloc_i && !clr_i && cnt_q == CTR_ST |=> cnt_q == CTR_ST); // R4
  AST_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_i && !taken_i && !alloc_i && !clr_i && cnt_q == CTR_SNT |=> cnt_q == CTR_SNT); // R4
endmodule

// File: rtl/brtgt_match.sv
module brtgt_match #(
  parameter int N  = 8,
  parameter int AW = 31,
  parameter int IW = 3
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][AW-1:0] tag_i,
  input  logic [N-1:0]         is_i,
  input  logic [AW-1:0]        q_addr_i,
  input  logic                 q_is_i,
  output logic [N-1:0]         match_o,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == q_addr_i) && (is_i[g] == q_is_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (match_o[i]) idx_o = IW'(i);
  end

  assign hit_o = |match_o;
endmodule

// File: rtl/brtgt_buf.sv
module brtgt_buf #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        alloc_mode_i,
  input  logic              flush_i,
  input  logic              pid_wr_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              lk_is_i,
  output logic              lk_hit_o,
  output logic              lk_taken_o,
  output logic [ADDR_W-1:0] lk_target_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic              upd_is_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic              upd_backward_i
);
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(NUM_ENTRIES - 1);

  logic [NUM_ENTRIES-1:0]             valid_v, is_v, lk_match, up_match;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] tag_v, tgt_v;
  logic [NUM_ENTRIES-1:0][1:0]        cnt_v;
  logic [IW-1:0] ptr_q, lk_idx, up_idx;
  logic lk_any, up_any;

  logic flush_all, upd_go, dir_ok, alloc_fire, train_fire;
  assign flush_all  = flush_i | pid_wr_i;
  assign upd_go     = upd_valid_i && en_i;
  assign dir_ok     = upd_backward_i ? alloc_mode_i[1] : alloc_mode_i[0];
  assign alloc_fire = upd_go && upd_taken_i && !up_any && dir_ok;
  assign train_fire = upd_go && up_any;

  brtgt_match #(.N(NUM_ENTRIES), .AW(ADDR_W), .IW(IW)) u_lk_match (
    .valid_i(valid_v), .tag_i(tag_v), .is_i(is_v),
    .q_addr_i(lk_addr_i), .q_is_i(lk_is_i),
    .match_o(lk_match), .hit_o(lk_any), .idx_o(lk_idx)
  );

  brtgt_match #(.N(NUM_ENTRIES), .AW(ADDR_W), .IW(IW)) u_up_match (
    .valid_i(valid_v), .tag_i(tag_v), .is_i(is_v),
    .q_addr_i(upd_addr_i), .q_is_i(upd_is_i),
    .match_o(up_match), .hit_o(up_any), .idx_o(up_idx)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    brtgt_entry #(.AW(ADDR_W)) u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (flush_all),
      .alloc_i (alloc_fire && ptr_q == IW'(g)),
      .train_i (train_fire && up_idx == IW'(g)),
      .taken_i (upd_taken_i),
      .addr_i  (upd_addr_i),
      .is_i    (upd_is_i),
      .tgt_i   (upd_target_i),
      .valid_o (valid_v[g]),
      .tag_o   (tag_v[g]),
      .is_o    (is_v[g]),
      .tgt_o   (tgt_v[g]),
      .cnt_o   (cnt_v[g])
    );
  end

  // FIFO victim pointer: advances only on a fresh allocation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= '0;
    else if (flush_all)  ptr_q <= '0;
    else if (alloc_fire) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign lk_hit_o    = en_i && lk_any;
  assign lk_taken_o  = lk_hit_o && cnt_v[lk_idx][1];
  assign lk_target_o = lk_hit_o ? tgt_v[lk_idx] : '0;

  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all |=> valid_v == '0); // R9
  AST_GROW_ON_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(valid_v) > $countones($past(valid_v)) |-> $past(upd_valid_i && upd_taken_i && en_i)); // R3
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_all && !alloc_fire |=> $stable(ptr_q)); // R7
  AST_ONE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match) && $onehot0(up_match)); // R8
  AST_DISABLED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !flush_all |=> $stable(valid_v) && $stable(cnt_v)); // R10
endmodule

// File: tb/brtgt_buf_tb.sv
module brtgt_buf_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic [1:0]  alloc_mode_i = 2'b11;
  logic        flush_i = 1'b0, pid_wr_i = 1'b0;
  logic [30:0] lk_addr_i = '0;
  logic        lk_is_i = 1'b0;
  logic        lk_hit_o, lk_taken_o;
  logic [30:0] lk_target_o;
  logic        upd_valid_i = 1'b0;
  logic [30:0] upd_addr_i = '0, upd_target_i = '0;
  logic        upd_is_i = 1'b0, upd_taken_i = 1'b0, upd_backward_i = 1'b0;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  brtgt_buf u_dut (
    .clk_i, .rst_ni, .en_i, .alloc_mode_i, .flush_i, .pid_wr_i,
    .lk_addr_i, .lk_is_i, .lk_hit_o, .lk_taken_o, .lk_target_o,
    .upd_valid_i, .upd_addr_i, .upd_is_i, .upd_taken_i, .upd_target_i, .upd_backward_i
  );

  task automatic chk_lk(input string req, input logic [30:0] a, input logic s,
                        input logic eh, input logic et, input logic [30:0] etg);
    lk_addr_i = a; lk_is_i = s; #1;
    n_chk++;
    if (lk_hit_o !== eh || lk_taken_o !== et || (eh && lk_target_o !== etg)) begin
      n_err++;
      $display("FAIL %s addr %h: hit/taken/tgt got %b/%b/%h exp %b/%b/%h",
               req, a, lk_hit_o, lk_taken_o, lk_target_o, eh, et, etg);
    end
  endtask

  task automatic upd(input logic [30:0] a, input logic s, input logic tk,
                     input logic [30:0] tg, input logic bw);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_addr_i = a; upd_is_i = s;
    upd_taken_i = tk; upd_target_i = tg; upd_backward_i = bw;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
  endtask

  task automatic pulse_flush(input bit pid);
    @(negedge clk_i);
    if (pid) pid_wr_i = 1'b1; else flush_i = 1'b1;
    @(negedge clk_i);
    pid_wr_i = 1'b0; flush_i = 1'b0;
  endtask

  task automatic t_reset;
    chk_lk("R1", 31'h0, 1'b0, 0, 0, 0);
    chk_lk("R1", 31'h100, 1'b0, 0, 0, 0);
    chk_lk("R1", 31'h7fff_ffff, 1'b1, 0, 0, 0);
  endtask

  task automatic t_alloc;
    upd(31'h100, 0, 1, 31'h200, 0);
    chk_lk("R2", 31'h100, 0, 1, 1, 31'h200);
    chk_lk("R6", 31'h100, 1, 0, 0, 0);
    chk_lk("R6", 31'h101, 0, 0, 0, 0);
    upd(31'h300, 0, 0, 31'h333, 0);
    chk_lk("R3", 31'h300, 0, 0, 0, 0);
  endtask

  task automatic t_counter; // entry 0x100 starts at 10
    upd(31'h100, 0, 1, 31'h200, 0); chk_lk("R4 10->11", 31'h100, 0, 1, 1, 31'h200);
    upd(31'h100, 0, 1, 31'h200, 0); chk_lk("R4 sat 11", 31'h100, 0, 1, 1, 31'h200);
    upd(31'h100, 0, 0, 31'h200, 0); chk_lk("R4 11->10", 31'h100, 0, 1, 1, 31'h200);
    upd(31'h100, 0, 0, 31'h200, 0); chk_lk("R4 10->01", 31'h100, 0, 1, 0, 31'h200);
    upd(31'h100, 0, 0, 31'h200, 0); chk_lk("R4 01->00", 31'h100, 0, 1, 0, 31'h200);
    upd(31'h100, 0, 0, 31'h200, 0); chk_lk("R4 sat 00", 31'h100, 0, 1, 0, 31'h200);
    upd(31'h100, 0, 1, 31'h200, 0); chk_lk("R4 00->01", 31'h100, 0, 1, 0, 31'h200);
    upd(31'h100, 0, 1, 31'h200, 0); chk_lk("R4 01->10", 31'h100, 0, 1, 1, 31'h200);
  endtask

  task automatic t_filter;
    pulse_flush(0);
    alloc_mode_i = 2'b01;
    upd(31'h400, 0, 1, 31'h4a0, 1); chk_lk("R5 bwd blocked", 31'h400, 0, 0, 0, 0);
    upd(31'h410, 0, 1, 31'h4b0, 0); chk_lk("R5 fwd allowed", 31'h410, 0, 1, 1, 31'h4b0);
    alloc_mode_i = 2'b10;
    upd(31'h420, 0, 1, 31'h4c0, 0); chk_lk("R5 fwd blocked", 31'h420, 0, 0, 0, 0);
    upd(31'h430, 1, 1, 31'h4d0, 1); chk_lk("R5 bwd allowed", 31'h430, 1, 1, 1, 31'h4d0);
    alloc_mode_i = 2'b00;
    upd(31'h440, 0, 1, 31'h4e0, 0); chk_lk("R5 none", 31'h440, 0, 0, 0, 0);
    upd(31'h410, 0, 0, 31'h4b0, 0); chk_lk("R5 existing trains", 31'h410, 0, 1, 0, 31'h4b0);
    alloc_mode_i = 2'b11;
  endtask

  task automatic t_flush;
    pulse_flush(0);
    chk_lk("R9 flush", 31'h410, 0, 0, 0, 0);
    chk_lk("R9 flush", 31'h430, 1, 0, 0, 0);
    upd(31'h500, 0, 1, 31'h5a0, 0); chk_lk("R9 realloc", 31'h500, 0, 1, 1, 31'h5a0);
    pulse_flush(1);
    chk_lk("R9 pid", 31'h500, 0, 0, 0, 0);
  endtask

  task automatic t_fifo;
    pulse_flush(0);
    upd(31'h1000, 0, 1, 31'h2000, 0);
    upd(31'h1000, 0, 1, 31'h2000, 0); // no duplicate; counter -> 11
    for (int i = 1; i <= 7; i++) upd(31'h1000 + 31'(i), 0, 1, 31'h2000 + 31'(i), 0);
    chk_lk("R8 oldest kept", 31'h1000, 0, 1, 1, 31'h2000);
    for (int i = 1; i <= 7; i++) chk_lk("R7 fill", 31'h1000 + 31'(i), 0, 1, 1, 31'h2000 + 31'(i));
    upd(31'h1008, 0, 1, 31'h2008, 0);
    chk_lk("R7 oldest evicted", 31'h1000, 0, 0, 0, 0);
    for (int i = 1; i <= 8; i++) chk_lk("R7 survivors", 31'h1000 + 31'(i), 0, 1, 1, 31'h2000 + 31'(i));
    upd(31'h1009, 0, 1, 31'h2009, 0);
    chk_lk("R7 second victim", 31'h1001, 0, 0, 0, 0);
    chk_lk("R7 newest", 31'h1009, 0, 1, 1, 31'h2009);
  endtask

  task automatic t_disable;
    @(negedge clk_i); en_i = 1'b0;
    chk_lk("R10 miss", 31'h1002, 0, 0, 0, 0);
    upd(31'h3000, 0, 1, 31'h3100, 0);
    upd(31'h1002, 0, 0, 31'h2002, 0);
    upd(31'h1002, 0, 0, 31'h2002, 0);
    @(negedge clk_i); en_i = 1'b1;
    chk_lk("R10 no alloc", 31'h3000, 0, 0, 0, 0);
    chk_lk("R10 no train", 31'h1002, 0, 1, 1, 31'h2002);
    chk_lk("R10 kept", 31'h1009, 0, 1, 1, 31'h2009);
  endtask

  initial begin
    #3;
    chk_lk("R1 in reset", 31'h100, 0, 0, 0, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_alloc();
    t_counter();
    t_filter();
    t_flush();
    t_fifo();
    t_disable();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule